// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block is one channel of a DMA request generator. It watches a bank of trigger lines, follows the single line named in its control register, and reacts to the edge type that the register selects. Each qualifying edge starts a burst. The burst is a programmed number of requests, each held toward a DMA controller until that controller acknowledges it. When the burst is complete the channel goes quiet until the next edge.

Software programs the channel through a plain write strobe and a 32-bit data word. The stored word can be read back at all times. The request count cannot be changed while the channel is running. An edge that arrives while a burst is still in flight is thrown away and sets a sticky overrun flag. That flag can drive an interrupt, and a dedicated input clears it.

Top module: `trig_burst_gen`

## Requirements
- R1: Control bits 4:0 name the trigger line that is followed; edges on any other line produce no request.
- R2: Control bits 18:17 choose the qualifying edge: 0 = none, 1 = low-to-high, 2 = high-to-low, 3 = either direction.
- R3: While control bit 16 (enable) is 0, no edge is detected and `dma_req` stays low.
- R4: Each qualifying edge seen while idle produces exactly N+1 requests, where N is control bits 23:19.
- R5: A request stays high until `dma_ack` is sampled high. `dma_req` is then low for exactly one cycle, and it rises again if requests remain.
- R6: A write leaves bits 23:19 unchanged when the stored enable bit is 1, while the other fields of that write still take effect.
- R7: After reset, `rd_data` reads 0 and `dma_req`, `ovr_flag` and `irq` are low.
- R8: A qualifying edge that arrives during an outstanding burst is dropped (the burst length does not change) and sets `ovr_flag`. The flag stays set until `ovr_clr` is sampled high. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq` is high exactly when `ovr_flag` is high and control bit 8 is 1.
- R10: If the enable bit is cleared during a burst, `dma_req` is low from the next clock on, and no leftover requests follow a later re-enable.
- R11: After a selected line changes level, `dma_req` rises at the third rising clock edge (two synchronizer stages plus one edge-history stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Stored control register value |
| trig_in | input | NUM_TRIG | Asynchronous trigger lines |
| dma_req | output | 1 | Request toward the DMA controller |
| dma_ack | input | 1 | Acknowledge of the current request |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Sticky overrun status |
| irq | output | 1 | Overrun interrupt |

## Verification
An overrun set and a clear request can land in the same cycle. The bench provokes this by re-arming the selected line during an unacknowledged burst and pulsing `ovr_clr` so that it is sampled at the exact edge where the dropped event registers; the flag must then read 1. The bench also sweeps every line select and every count value, and runs all edge modes in both directions. Request counts are compared with N+1 or zero, worked out from the configuration.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int SEL_W    = 5;
  localparam int CNT_W    = 5;
  localparam int SEL_LSB  = 0;
  localparam int IE_BIT   = 8;
  localparam int EN_BIT   = 16;
  localparam int MODE_LSB = 17;
  localparam int CNT_LSB  = 19;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    edge_mode_e       mode;
    logic             en;
    logic             ie;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } burst_st_e;
endpackage

// File: rtl/trg_ctrl_reg.sv
module trg_ctrl_reg
  import trg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output ctrl_t       ctrl,
  output logic [31:0] rd_data
);
  ctrl_t ctrl_q;
  logic  unused_bits;

  assign unused_bits = ^{wr_data[31:24], wr_data[15:9], wr_data[7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.sel  <= wr_data[SEL_LSB +: SEL_W];
      ctrl_q.ie   <= wr_data[IE_BIT];
      ctrl_q.en   <= wr_data[EN_BIT];
      ctrl_q.mode <= edge_mode_e'(wr_data[MODE_LSB +: 2]);
      if (!ctrl_q.en)
        ctrl_q.cnt <= wr_data[CNT_LSB +: CNT_W];
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[SEL_LSB +: SEL_W]    = ctrl_q.sel;
    rd_data[IE_BIT]              = ctrl_q.ie;
    rd_data[EN_BIT]              = ctrl_q.en;
    rd_data[MODE_LSB +: 2]       = ctrl_q.mode;
    rd_data[CNT_LSB +: CNT_W]    = ctrl_q.cnt;
  end

  assign ctrl = ctrl_q;

  AST_CNT_LOCK: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.en |=> $stable(ctrl_q.cnt)); // R6
endmodule

// File: rtl/trg_sync.sv
module trg_sync #(
  parameter int NUM_TRIG    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] lines_in,
  output logic [NUM_TRIG-1:0] lines_now,
  output logic [NUM_TRIG-1:0] lines_old
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [NUM_TRIG-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= lines_in;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign lines_now = stg[SYNC_STAGES-1];
  assign lines_old = stg[SYNC_STAGES];
endmodule

// File: rtl/trg_edge.sv
module trg_edge
  import trg_pkg::*;
#(
  parameter int NUM_TRIG = 32
) (
  input  logic [NUM_TRIG-1:0] lines_now,
  input  logic [NUM_TRIG-1:0] lines_old,
  input  logic [SEL_W-1:0]    sel,
  input  edge_mode_e          mode,
  input  logic                en,
  output logic                evt
);
  logic cur, prv, rise, fall;

  always_comb begin
    cur = 1'b0;
    prv = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (sel == SEL_W'(i)) begin
        cur = lines_now[i];
        prv = lines_old[i];
      end
    end
  end

  assign rise = cur & ~prv;
  assign fall = ~cur & prv;

  always_comb begin
    unique case (mode)
      EDGE_RISE: evt = en & rise;
      EDGE_FALL: evt = en & fall;
      EDGE_BOTH: evt = en & (rise | fall);
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/trg_burst.sv
module trg_burst
  import trg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ack,
  input  logic             ovr_clr,
  output logic             req,
  output logic             ovr
);
  burst_st_e        st;
  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      rem <= '0;
    end else if (!en) begin
      st  <= ST_IDLE;
      rem <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (evt) begin
          st  <= ST_REQ;
          rem <= cnt;
        end
        ST_REQ: if (ack) begin
          if (rem == '0) st <= ST_IDLE;
          else begin
            rem <= rem - 1'b1;
            st  <= ST_GAP;
          end
        end
        ST_GAP:  st <= ST_REQ;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         ovr <= 1'b0;
    else if (evt && st != ST_IDLE)   ovr <= 1'b1;
    else if (ovr_clr)                ovr <= 1'b0;
  end

  assign req = (st == ST_REQ);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req && !ack && en |=> req); // R5
  AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    req && ack |=> !req); // R5
  AST_NO_REQ_DIS: assert property (@(posedge clk) disable iff (rst)
    !en |=> !req); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr && !ovr_clr |=> ovr); // R8
  AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE && evt |=> req); // R4
endmodule

// File: rtl/trig_burst_gen.sv
module trig_burst_gen
  import trg_pkg::*;
#(
  parameter int NUM_TRIG    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  input  logic [NUM_TRIG-1:0] trig_in,
  output logic                dma_req,
  input  logic                dma_ack,
  input  logic                ovr_clr,
  output logic                ovr_flag,
  output logic                irq
);
  ctrl_t               ctrl;
  logic [NUM_TRIG-1:0] lines_now, lines_old;
  logic                evt;

  trg_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl(ctrl), .rd_data(rd_data)
  );

  trg_sync #(.NUM_TRIG(NUM_TRIG), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .lines_in(trig_in),
    .lines_now(lines_now), .lines_old(lines_old)
  );

  trg_edge #(.NUM_TRIG(NUM_TRIG)) u_edge (
    .lines_now(lines_now), .lines_old(lines_old), .sel(ctrl.sel),
    .mode(ctrl.mode), .en(ctrl.en), .evt(evt)
  );

  trg_burst u_burst (
    .clk(clk), .rst(rst), .en(ctrl.en), .evt(evt), .cnt(ctrl.cnt),
    .ack(dma_ack), .ovr_clr(ovr_clr), .req(dma_req), .ovr(ovr_flag)
  );

  assign irq = ovr_flag & ctrl.ie;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovr_flag); // R9
endmodule

// File: tb/test_trig_burst_gen.sv
module test_trig_burst_gen;
  localparam int NT = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NT-1:0] trig = '0;
  logic          dma_req;
  logic          dma_ack = 1'b0;
  logic          ovr_clr = 1'b0;
  logic          ovr_flag;
  logic          irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trig_burst_gen #(.NUM_TRIG(NT)) i_trig_burst_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .trig_in(trig), .dma_req(dma_req), .dma_ack(dma_ack), .ovr_clr(ovr_clr),
    .ovr_flag(ovr_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input int sel, input int ie, input int en, input int mode, input int cnt);
    @(negedge clk);
    wr_data = (32'(cnt) << 19) | (32'(mode) << 17) | (32'(en) << 16) | (32'(ie) << 8) | 32'(sel);
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_line(input int idx, input bit v);
    @(negedge clk);
    trig[idx] = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dma_req) break;
    end
  endtask

  task automatic run_burst(output int n);
    int quiet;
    n = 0;
    quiet = 0;
    for (int i = 0; i < 400 && quiet < 12; i++) begin
      @(negedge clk);
      if (dma_req) begin
        n++;
        quiet = 0;
        dma_ack = 1'b1;
      end else begin
        dma_ack = 1'b0;
        quiet++;
      end
    end
    dma_ack = 1'b0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int n;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 0, "R7 rd_data", rd_data, 0);
    chk(!dma_req && !ovr_flag && !irq, "R7 outputs", {dma_req, ovr_flag, irq}, 0);

    // R4, R1, R2: every select with count equal to the select
    for (int s = 0; s < NT; s++) begin
      wr_ctrl(0, 0, 0, 0, 0);
      wr_ctrl(s, 0, 1, 1, s);
      set_line(s, 1'b1);
      run_burst(n);
      chk(n == s + 1, "R4 burst length", n, s + 1);
      set_line(s, 1'b0);
      run_burst(n);
      chk(n == 0, "R2 falling ignored in rise mode", n, 0);
      set_line((s + 1) % NT, 1'b1);
      set_line((s + 1) % NT, 1'b0);
      run_burst(n);
      chk(n == 0, "R1 other line ignored", n, 0);
    end

    // R2: all modes, both directions, line 3, count 1
    for (int m = 0; m < 4; m++) begin
      wr_ctrl(0, 0, 0, 0, 0);
      wr_ctrl(3, 0, 1, m, 1);
      set_line(3, 1'b1);
      run_burst(n);
      chk(n == (((m & 1) != 0) ? 2 : 0), "R2 rising edge", n, ((m & 1) != 0) ? 2 : 0);
      set_line(3, 1'b0);
      run_burst(n);
      chk(n == (((m & 2) != 0) ? 2 : 0), "R2 falling edge", n, ((m & 2) != 0) ? 2 : 0);
    end

    // R3: disabled channel
    wr_ctrl(4, 0, 0, 3, 2);
    set_line(4, 1'b1);
    set_line(4, 1'b0);
    run_burst(n);
    chk(n == 0, "R3 disabled no requests", n, 0);

    // R11 latency and R5 hold and gap
    wr_ctrl(5, 0, 1, 1, 1);
    @(negedge clk);
    trig[5] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(!dma_req, "R11 not before third edge", dma_req, 0);
    @(posedge clk);
    @(negedge clk);
    chk(dma_req, "R11 request at third edge", dma_req, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(dma_req, "R5 held without ack", dma_req, 1);
    end
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    chk(!dma_req, "R5 gap after ack", dma_req, 0);
    @(negedge clk);
    chk(dma_req, "R5 reassert for remaining", dma_req, 1);
    run_burst(n);
    chk(n == 1, "R5 remaining count", n, 1);

    // R6: count lock
    wr_ctrl(5, 0, 0, 1, 3);
    wr_ctrl(5, 0, 1, 1, 3);
    wr_ctrl(4, 0, 1, 1, 9);
    chk(rd_data[23:19] == 3, "R6 count locked", rd_data[23:19], 3);
    chk(rd_data[4:0] == 4, "R6 select still written", rd_data[4:0], 4);
    wr_ctrl(4, 0, 0, 1, 9);
    chk(rd_data[23:19] == 3, "R6 locked on disabling write", rd_data[23:19], 3);
    wr_ctrl(4, 0, 0, 1, 9);
    chk(rd_data[23:19] == 9, "R6 writable when disabled", rd_data[23:19], 9);

    // R8, R9: overrun with interrupt enabled
    wr_ctrl(7, 1, 1, 1, 2);
    set_line(7, 1'b1);
    wait_req();
    set_line(7, 1'b0);
    idle(3);
    set_line(7, 1'b1);
    idle(4);
    chk(ovr_flag, "R8 overrun set", ovr_flag, 1);
    chk(irq, "R9 irq enabled", irq, 1);
    run_burst(n);
    chk(n == 3, "R8 dropped event no extra requests", n, 3);
    chk(ovr_flag, "R8 flag sticky", ovr_flag, 1);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(!ovr_flag && !irq, "R8 clear", {ovr_flag, irq}, 0);

    // R9 masked, then unmasked; R8 set beats clear
    wr_ctrl(7, 0, 1, 1, 2);
    set_line(7, 1'b0);
    idle(3);
    set_line(7, 1'b1);
    wait_req();
    set_line(7, 1'b0);
    idle(3);
    set_line(7, 1'b1);
    idle(4);
    chk(ovr_flag && !irq, "R9 irq masked", irq, 0);
    wr_ctrl(7, 1, 1, 1, 2);
    chk(irq, "R9 irq after unmask", irq, 1);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(!ovr_flag, "R8 cleared before race", ovr_flag, 0);
    set_line(7, 1'b0);
    idle(3);
    @(negedge clk);
    trig[7] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(ovr_flag, "R8 set wins over clear", ovr_flag, 1);
    run_burst(n);
    chk(n == 3, "R8 burst unchanged after race", n, 3);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;

    // R10: abort
    wr_ctrl(9, 0, 0, 1, 5);
    wr_ctrl(9, 0, 1, 1, 5);
    set_line(9, 1'b1);
    wait_req();
    @(negedge clk);
    wr_data = (32'd5 << 19) | (32'd1 << 17) | 32'd9;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!dma_req, "R10 request dropped after disable", dma_req, 0);
    wr_ctrl(9, 0, 1, 1, 5);
    run_burst(n);
    chk(n == 0, "R10 no leftover after re-enable", n, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule